// File: doc/BRIEF.md
# Transceiver attribute write sequencer

This block is a small register-bus master. After a line-rate change, the transceiver's analog front end has to be told to use preset adaptation settings. This block writes those settings through a byte-wide mailbox. A single start pulse begins the run. For each entry of a parameterised table of attribute code/value pairs, the block does the following in order:

- fills four staging registers;
- fires a trigger bit;
- confirms that the mailbox status flag came up;
- polls a busy bit until it drops;
- acknowledges the flag with a write-one-to-clear.

When every pair has gone through, it reports completion with a one-cycle pulse. It reports an error instead if the status flag is missing or the busy poll runs past a cycle budget. That budget is derived from the clock frequency, so the whole reprogramming stays inside the readiness window that follows a rate switch.

Every access is a single request held on the bus until the responder answers with ready. Read data is taken in the cycle that ready is high. Bit-level writes carry zeros in every other bit of the byte.

Top module: `xcvr_attr_seq`

## Requirements
- R1: While reset is asserted and after its release, busReq_o, done_o and error_o are 0 until a start pulse arrives.
- R2: For each pair, the first four accesses are writes: value bits [7:0] to address 0x84, then value bits [15:8] to 0x85, then code bits [7:0] to 0x86, then code bits [15:8] to 0x87.
- R3: After the staging writes, the block writes 0x01 to address 0x90 (trigger in bit 0).
- R4: It then reads address 0x8A. If bit 7 of the returned byte is 0, error_o pulses and the block issues no further bus request until the next start.
- R5: Once the flag is seen, it reads address 0x8B repeatedly and leaves the poll on the first read whose bit 0 is 0.
- R6: After the poll, it writes 0x80 to address 0x8A, which clears the flag (bit 7 is write-one-to-clear).
- R7: Pairs are processed strictly in table order, with the next pair's staging starting only after the previous clear. The default table is code 0x2C with value 0x118, then code 0x6C with value 0x000.
- R8: While busReq_o is high and busReady_i is low, busReq_o, busWe_o, busAddr_o and busWdata_o hold their values into the next cycle.
- R9: If the busy poll has lasted POLL_LIMIT cycles (CLK_HZ/1e6 × POLL_TIMEOUT_US), the next busy read raises error_o for one cycle, the run stops with no clear write, and done_o stays 0.
- R10: done_o pulses for exactly one cycle, in the cycle after the final pair's clear write is accepted, and never together with error_o.
- R11: A start pulse received while a run is in progress has no effect: the access sequence and the single done pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to run the pair table |
| busReq_o | output | 1 | Bus access request (valid) |
| busWe_o | output | 1 | 1 = write, 0 = read |
| busAddr_o | output | 8 | Register address |
| busWdata_o | output | 8 | Write data |
| busRdata_i | input | 8 | Read data, sampled when busReady_i is high |
| busReady_i | input | 1 | Responder accepts the current access |
| done_o | output | 1 | One-cycle pulse: all pairs written |
| error_o | output | 1 | One-cycle pulse: flag missing or poll timeout |

## Verification
A request becomes visible one cycle after the edge that accepts the previous access, so the bench's responder judges each request at the falling edge and records it as transferred at the following rising edge. done_o is due exactly one cycle after the final clear write is accepted, and the bench compares that cycle number with the one it logged for the clear. With the responder answering at once, a stuck busy bit must raise error_o exactly POLL_LIMIT cycles after the first busy read appears, and the bench checks that distance. The flag-failure case is checked twelve cycles later for the absence of any further request.

// File: rtl/xas_pkg.sv
package xas_pkg;

  parameter int BUS_AW = 8;
  parameter int BUS_DW = 8;

  // Mailbox register map (order of use is part of the handshake)
  parameter logic [BUS_AW-1:0] A_VAL_LO  = 8'h84;
  parameter logic [BUS_AW-1:0] A_VAL_HI  = 8'h85;
  parameter logic [BUS_AW-1:0] A_CODE_LO = 8'h86;
  parameter logic [BUS_AW-1:0] A_CODE_HI = 8'h87;
  parameter logic [BUS_AW-1:0] A_TRIG    = 8'h90;
  parameter logic [BUS_AW-1:0] A_FLAG    = 8'h8A;
  parameter logic [BUS_AW-1:0] A_BUSY    = 8'h8B;

  parameter logic [BUS_DW-1:0] M_TRIG = 8'h01;
  parameter logic [BUS_DW-1:0] M_FLAG = 8'h80;
  parameter logic [BUS_DW-1:0] M_BUSY = 8'h01;

  typedef enum logic [2:0] {
    ACC_VLO,
    ACC_VHI,
    ACC_CLO,
    ACC_CHI,
    ACC_TRIG,
    ACC_FLAGRD,
    ACC_BUSYRD,
    ACC_FLAGCLR
  } acc_e;

  typedef struct packed {
    acc_e acc;
    logic pairClr;
    logic pairInc;
    logic tmrClr;
    logic tmrEn;
  } ctl_s;

endpackage

// File: rtl/xas_dp.sv
module xas_dp
  import xas_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter logic [NUM_PAIRS*16-1:0] PAIR_CODES  = {16'h006C, 16'h002C},
  parameter logic [NUM_PAIRS*16-1:0] PAIR_VALUES = {16'h0000, 16'h0118},
  parameter int POLL_LIMIT = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_s              ctl,
  output logic              we,
  output logic [BUS_AW-1:0] addr,
  output logic [BUS_DW-1:0] wdata,
  output logic              lastPair,
  output logic              pollExpired
);

  localparam int IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
  localparam int TMR_W = $clog2(POLL_LIMIT + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PAIRS - 1);
  localparam logic [TMR_W-1:0] TMR_END  = TMR_W'(POLL_LIMIT - 1);

  logic [15:0] codeTab [NUM_PAIRS];
  logic [15:0] valTab  [NUM_PAIRS];

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_tab
    assign codeTab[g] = PAIR_CODES[g*16 +: 16];
    assign valTab[g]  = PAIR_VALUES[g*16 +: 16];
  end

  logic [IDX_W-1:0] pairIdx;
  logic [TMR_W-1:0] tmr;
  logic [15:0]      curCode;
  logic [15:0]      curVal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pairIdx <= '0;
    end else if (ctl.pairClr) begin
      pairIdx <= '0;
    end else if (ctl.pairInc && !lastPair) begin
      pairIdx <= pairIdx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr <= '0;
    end else if (ctl.tmrClr) begin
      tmr <= '0;
    end else if (ctl.tmrEn && !pollExpired) begin
      tmr <= tmr + TMR_W'(1);
    end
  end

  assign lastPair    = (pairIdx == LAST_IDX);
  assign pollExpired = (tmr >= TMR_END);
  assign curCode     = codeTab[pairIdx];
  assign curVal      = valTab[pairIdx];

  always_comb begin
    we    = 1'b1;
    addr  = A_VAL_LO;
    wdata = '0;
    unique case (ctl.acc)
      ACC_VLO:     begin addr = A_VAL_LO;  wdata = curVal[7:0];   end
      ACC_VHI:     begin addr = A_VAL_HI;  wdata = curVal[15:8];  end
      ACC_CLO:     begin addr = A_CODE_LO; wdata = curCode[7:0];  end
      ACC_CHI:     begin addr = A_CODE_HI; wdata = curCode[15:8]; end
      ACC_TRIG:    begin addr = A_TRIG;    wdata = M_TRIG;        end
      ACC_FLAGRD:  begin addr = A_FLAG;    we = 1'b0;             end
      ACC_BUSYRD:  begin addr = A_BUSY;    we = 1'b0;             end
      ACC_FLAGCLR: begin addr = A_FLAG;    wdata = M_FLAG;        end
      default:     begin addr = A_VAL_LO;                         end
    endcase
  end

  // R9: the poll timer never runs past its limit
  p_tmr_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmr <= TMR_END);

  // R7: the pair index stays inside the table
  p_pair_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pairIdx <= LAST_IDX);

  // R7: a new pair starts only from a clear access
  p_pair_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.pairInc && !lastPair) |-> ctl.acc == ACC_FLAGCLR);

endmodule

// File: rtl/xas_ctrl.sv
module xas_ctrl
  import xas_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ready,
  input  logic [BUS_DW-1:0] rdata,
  input  logic              lastPair,
  input  logic              pollExpired,
  output ctl_s              ctl,
  output logic              req,
  output logic              done,
  output logic              error
);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_VLO,
    ST_VHI,
    ST_CLO,
    ST_CHI,
    ST_TRIG,
    ST_FLAG,
    ST_POLL,
    ST_CLR
  } state_e;

  state_e state, stateNext;
  logic   flagSet;
  logic   busySet;
  logic   doneQ, errQ;
  logic   doneSet, errSet;

  assign flagSet = (rdata & M_FLAG) != '0;
  assign busySet = (rdata & M_BUSY) != '0;

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    ctl.acc     = ACC_VLO;
    req         = 1'b0;
    doneSet     = 1'b0;
    errSet      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.pairClr = 1'b1;
          stateNext   = ST_VLO;
        end
      end
      ST_VLO: begin
        req = 1'b1; ctl.acc = ACC_VLO;
        if (ready) stateNext = ST_VHI;
      end
      ST_VHI: begin
        req = 1'b1; ctl.acc = ACC_VHI;
        if (ready) stateNext = ST_CLO;
      end
      ST_CLO: begin
        req = 1'b1; ctl.acc = ACC_CLO;
        if (ready) stateNext = ST_CHI;
      end
      ST_CHI: begin
        req = 1'b1; ctl.acc = ACC_CHI;
        if (ready) stateNext = ST_TRIG;
      end
      ST_TRIG: begin
        req = 1'b1; ctl.acc = ACC_TRIG;
        if (ready) stateNext = ST_FLAG;
      end
      ST_FLAG: begin
        req = 1'b1; ctl.acc = ACC_FLAGRD;
        if (ready) begin
          if (flagSet) begin
            ctl.tmrClr = 1'b1;
            stateNext  = ST_POLL;
          end else begin
            errSet    = 1'b1;
            stateNext = ST_IDLE;
          end
        end
      end
      ST_POLL: begin
        req = 1'b1; ctl.acc = ACC_BUSYRD; ctl.tmrEn = 1'b1;
        if (ready) begin
          if (!busySet) begin
            stateNext = ST_CLR;
          end else if (pollExpired) begin
            errSet    = 1'b1;
            stateNext = ST_IDLE;
          end
        end
      end
      ST_CLR: begin
        req = 1'b1; ctl.acc = ACC_FLAGCLR;
        if (ready) begin
          if (lastPair) begin
            doneSet   = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            ctl.pairInc = 1'b1;
            stateNext   = ST_VLO;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= doneSet;
      errQ  <= errSet;
    end
  end

  assign done  = doneQ;
  assign error = errQ;

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: completion and failure never coincide
  p_done_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  // R9: failure is a single-cycle pulse
  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error);

  // R11: a start while running leaves the run going
  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {ST_VLO, ST_VHI, ST_CLO, ST_CHI} && start) |=> state != ST_IDLE);

endmodule

// File: rtl/xcvr_attr_seq.sv
module xcvr_attr_seq
  import xas_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter logic [NUM_PAIRS*16-1:0] PAIR_CODES  = {16'h006C, 16'h002C},
  parameter logic [NUM_PAIRS*16-1:0] PAIR_VALUES = {16'h0000, 16'h0118},
  parameter int CLK_HZ = 200_000_000,
  parameter int POLL_TIMEOUT_US = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output logic       busReq_o,
  output logic       busWe_o,
  output logic [7:0] busAddr_o,
  output logic [7:0] busWdata_o,
  input  logic [7:0] busRdata_i,
  input  logic       busReady_i,
  output logic       done_o,
  output logic       error_o
);

  localparam int POLL_LIMIT = (CLK_HZ / 1_000_000) * POLL_TIMEOUT_US;

  ctl_s ctl;
  logic lastPair;
  logic pollExpired;

  xas_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_i),
    .ready       (busReady_i),
    .rdata       (busRdata_i),
    .lastPair    (lastPair),
    .pollExpired (pollExpired),
    .ctl         (ctl),
    .req         (busReq_o),
    .done        (done_o),
    .error       (error_o)
  );

  xas_dp #(
    .NUM_PAIRS   (NUM_PAIRS),
    .PAIR_CODES  (PAIR_CODES),
    .PAIR_VALUES (PAIR_VALUES),
    .POLL_LIMIT  (POLL_LIMIT)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .we          (busWe_o),
    .addr        (busAddr_o),
    .wdata       (busWdata_o),
    .lastPair    (lastPair),
    .pollExpired (pollExpired)
  );

  // R8: a pending request holds steady until accepted
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busReq_o && !busReady_i) |=> busReq_o && $stable(busAddr_o)
      && $stable(busWe_o) && $stable(busWdata_o));

  // R4: failure leaves the bus idle
  p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> !busReq_o);

  // R6: the flag register is only ever written with its clear bit
  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busReq_o && busWe_o && busAddr_o == A_FLAG) |-> busWdata_o == M_FLAG);

  // R3: the trigger write carries only bit 0
  p_trig_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busReq_o && busWe_o && busAddr_o == A_TRIG) |-> busWdata_o == M_TRIG);

endmodule

// File: tb/xcvr_attr_seq_tb.sv
module xcvr_attr_seq_tb;

  localparam int LIMIT = 200; // 200 MHz, 1 us poll budget

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       busReq_o, busWe_o, done_o, error_o;
  logic [7:0] busAddr_o, busWdata_o;
  logic [7:0] busRdata_i = '0;
  logic       busReady_i = 1'b0;

  always #2.5 clk = ~clk;

  xcvr_attr_seq #(.CLK_HZ(200_000_000), .POLL_TIMEOUT_US(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .busReq_o(busReq_o), .busWe_o(busWe_o), .busAddr_o(busAddr_o),
    .busWdata_o(busWdata_o), .busRdata_i(busRdata_i), .busReady_i(busReady_i),
    .done_o(done_o), .error_o(error_o)
  );

  int checks = 0, errors = 0;
  int cyc = 0;

  // responder configuration
  int cfgPollReads = 0, cfgMaxDelay = 0;
  bit cfgFlagOk = 1, cfgBusyForever = 0;

  // responder state and logs
  bit   flag = 0;
  int   busyLeft = 0, waitLeft = 0;
  bit   logWe [0:511];
  logic [7:0] logAddr [0:511];
  logic [7:0] logData [0:511];
  int   logN = 0;
  int   doneCnt = 0, errCnt = 0, doneCyc = -1, errCyc = -1;
  int   lastClrCyc = -1, firstPollCyc = -1, holdBad = 0;
  bit   prevPend = 0;
  logic [7:0] prevAddr = '0, prevWdata = '0;
  bit   prevWe = 0;

  // expected sequence
  bit   expWe [0:511];
  logic [7:0] expAddr [0:511];
  logic [7:0] expData [0:511];
  int   expN = 0;

  function automatic logic [15:0] pairCode(int p);
    return (p == 0) ? 16'h002C : 16'h006C;
  endfunction

  function automatic logic [15:0] pairVal(int p);
    return (p == 0) ? 16'h0118 : 16'h0000;
  endfunction

  function automatic string reqOf(logic [7:0] a, bit w);
    if (a >= 8'h84 && a <= 8'h87) return "R2";
    if (a == 8'h90) return "R3";
    if (a == 8'h8A) return w ? "R6" : "R4";
    if (a == 8'h8B) return "R5";
    return "R7";
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic addExp(bit w, logic [7:0] a, logic [7:0] d);
    expWe[expN] = w; expAddr[expN] = a; expData[expN] = d; expN++;
  endtask

  // full expected access list; stopAfterFlag leaves the run at the first flag read
  task automatic buildExp(int pollReads, bit stopAfterFlag);
    expN = 0;
    for (int p = 0; p < 2; p++) begin
      addExp(1, 8'h84, pairVal(p)[7:0]);
      addExp(1, 8'h85, pairVal(p)[15:8]);
      addExp(1, 8'h86, pairCode(p)[7:0]);
      addExp(1, 8'h87, pairCode(p)[15:8]);
      addExp(1, 8'h90, 8'h01);
      addExp(0, 8'h8A, 8'h00);
      if (stopAfterFlag) return;
      for (int k = 0; k <= pollReads; k++) addExp(0, 8'h8B, 8'h00);
      addExp(1, 8'h8A, 8'h80);
    end
  endtask

  task automatic compareLog(int n);
    for (int i = 0; i < n; i++) begin
      bit ok;
      ok = (i < logN) && logWe[i] == expWe[i] && logAddr[i] == expAddr[i]
           && (!expWe[i] || logData[i] == expData[i]);
      check(ok, reqOf(expAddr[i], expWe[i]), $sformatf("access %0d addr/data", i),
            (i < logN) ? {logWe[i], logAddr[i], logData[i]} : -1,
            {expWe[i], expAddr[i], expData[i]});
    end
  endtask

  // responder, monitor and watchdog, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
      if (!rst_n) begin
        busReady_i = 0; prevPend = 0;
        continue;
      end
      if (done_o) begin doneCnt++; doneCyc = cyc; end
      if (error_o) begin errCnt++; errCyc = cyc; end
      if (prevPend && !(busReq_o && busAddr_o == prevAddr && busWe_o == prevWe
                        && busWdata_o == prevWdata)) holdBad++;
      if (busReq_o && !busWe_o && busAddr_o == 8'h8B && firstPollCyc < 0)
        firstPollCyc = cyc;
      if (busReq_o) begin
        if (waitLeft == 0) begin
          busReady_i = 1;
          logWe[logN] = busWe_o; logAddr[logN] = busAddr_o;
          if (busWe_o) begin
            busRdata_i = 8'h00;
            logData[logN] = busWdata_o;
            if (busAddr_o == 8'h90 && busWdata_o[0]) begin
              flag = cfgFlagOk; busyLeft = cfgPollReads;
            end
            if (busAddr_o == 8'h8A && busWdata_o[7]) begin
              flag = 0; lastClrCyc = cyc;
            end
          end else begin
            if (busAddr_o == 8'h8A) busRdata_i = {flag, 7'b0};
            else if (busAddr_o == 8'h8B) begin
              busRdata_i = {7'b0, (cfgBusyForever || busyLeft > 0)};
              if (busyLeft > 0) busyLeft--;
            end else busRdata_i = 8'h00;
            logData[logN] = busRdata_i;
          end
          if (logN < 511) logN++;
          waitLeft = (cfgMaxDelay > 0) ? $urandom_range(cfgMaxDelay, 0) : 0;
          prevPend = 0;
        end else begin
          busReady_i = 0;
          waitLeft--;
          prevPend = 1; prevAddr = busAddr_o; prevWe = busWe_o; prevWdata = busWdata_o;
        end
      end else begin
        busReady_i = 0; prevPend = 0;
      end
    end
  end

  task automatic runSeq(int pollReads, bit flagOk, bit busyForever, int maxDelay, bit midStart);
    cfgPollReads = pollReads; cfgFlagOk = flagOk; cfgBusyForever = busyForever;
    cfgMaxDelay = maxDelay; waitLeft = 0;
    @(negedge clk);
    logN = 0; doneCnt = 0; errCnt = 0; doneCyc = -1; errCyc = -1;
    lastClrCyc = -1; firstPollCyc = -1; holdBad = 0;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    if (midStart) begin
      repeat (8) @(negedge clk);
      start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    for (int i = 0; i < 5000 && doneCnt + errCnt == 0; i++) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic checkGoodRun(string tag, int pollReads);
    buildExp(pollReads, 0);
    compareLog(expN);
    check(logN == expN, "R7", {tag, " access count"}, logN, expN);
    check(doneCnt == 1, "R10", {tag, " done pulses"}, doneCnt, 1);
    check(errCnt == 0, "R10", {tag, " error pulses"}, errCnt, 0);
    check(doneCyc == lastClrCyc + 1, "R10", {tag, " done cycle"}, doneCyc, lastClrCyc + 1);
    check(holdBad == 0, "R8", {tag, " request hold"}, holdBad, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0;
    repeat (4) @(negedge clk);
    check(!busReq_o && !done_o && !error_o, "R1", "outputs in reset",
          {busReq_o, done_o, error_o}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!busReq_o && !done_o && !error_o, "R1", "outputs idle after reset",
          {busReq_o, done_o, error_o}, 0);

    // directed: default table, two busy polls, zero wait
    runSeq(2, 1, 0, 0, 0);
    checkGoodRun("directed", 2);

    // directed: busy already clear on first poll, slow responder
    runSeq(0, 1, 0, 3, 0);
    checkGoodRun("fast-busy", 0);

    // R4: status flag missing
    runSeq(0, 0, 0, 0, 0);
    buildExp(0, 1);
    compareLog(expN);
    check(logN == 6, "R4", "accesses after missing flag", logN, 6);
    check(errCnt == 1 && doneCnt == 0, "R4", "error pulse on missing flag",
          {errCnt[3:0], doneCnt[3:0]}, 8'h10);
    check(!busReq_o, "R4", "bus quiet after error", busReq_o, 0);

    // R9: busy never clears
    runSeq(0, 1, 1, 0, 0);
    check(errCnt == 1 && doneCnt == 0, "R9", "timeout error pulse",
          {errCnt[3:0], doneCnt[3:0]}, 8'h10);
    check(errCyc - firstPollCyc == LIMIT, "R9", "timeout distance",
          errCyc - firstPollCyc, LIMIT);
    begin
      int clrSeen = 0;
      for (int i = 0; i < logN; i++) if (logWe[i] && logAddr[i] == 8'h8A) clrSeen++;
      check(clrSeen == 0, "R9", "no clear write after timeout", clrSeen, 0);
    end
    check(!busReq_o, "R9", "bus quiet after timeout", busReq_o, 0);

    // R11: start pulse in the middle of a run
    runSeq(1, 1, 0, 0, 1);
    checkGoodRun("R11 mid-start", 1);

    // recovery after failure plus random runs
    for (int r = 0; r < 8; r++) begin
      int pr, md;
      pr = $urandom_range(5, 0);
      md = $urandom_range(3, 0);
      runSeq(pr, 1, 0, md, r[0]);
      checkGoodRun($sformatf("random %0d", r), pr);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule